// File: doc/BRIEF.md
# Variable-Page Address Translation Lookup with Fault Classification

This block turns a 32-bit virtual address into a 29-bit physical address. It searches a small, fully associative table of translation entries. Each entry carries its own page size: 1 KB, 4 KB, 64 KB or 1 MB. An entry holds the following fields:

- a virtual page number and an address-space tag;
- valid, shared and dirty flags;
- a two-bit permission field;
- a size code;
- a physical page number.

A requester presents an address with the following qualifiers:

- the access kind: instruction fetch, data read or data write;
- the privileged-mode bit;
- the single-address-space bit;
- the translation-enable bit;
- the current address-space tag.

One cycle later the block returns one of two results. On success it returns the physical address. Otherwise it raises a fault flag with a fault code that tells a handler what went wrong: miss, multiple hit, protection violation, first write to a clean page, or an address error. Two address windows skip the table altogether: 0x80000000–0xBFFFFFFF and everything at or above 0xE0000000.

Entries are loaded through a single write port that names the slot index. On most faults the block also returns the faulting virtual page number, so that a page-table-entry high register next to the block can latch it for the miss handler.

Top module: `vtlb_xlate`

## Requirements
- R1: A response appears on `rsp_valid` exactly one cycle after each `req_valid` cycle and at no other time; all response fields are registered.
- R2: Size code 0/1/2/3 selects a 1 KB/4 KB/64 KB/1 MB page. An entry matches every address in the single page-aligned range that contains its stored page number × 1024. The page-number bits below the page size are ignored.
- R3: An entry matches only when its valid flag is set. The address-space tags must also be equal, except in two cases: the entry's shared flag is set, or both `priv` and `single_virt` are 1.
- R4: If two or more entries match a translated access, the fault code is 0x140, and `rsp_vpn_valid` stays 0.
- R5: A translated access that matches no entry faults with 0x040 for a fetch or a read and with 0x060 for a write. `req_kind` encoding: 0 fetch, 1 read, 2 write, 3 is treated as a read.
- R6: A user-mode access (`priv`=0) to an entry whose permission bit 1 is 0 faults with 0x0A0 for a fetch or a read and with 0x0C0 for a write.
- R7: The following checks apply when the R6 check passes, in this order:
  - a write to an entry whose permission bit 0 is 0 faults with 0x0C0;
  - otherwise, a write to an entry whose dirty flag is 0 faults with 0x080;
  - fetches and reads ignore permission bit 0 and the dirty flag.
- R8: On a single hit without fault, physical bits [28:10] are the entry's page number with the bits below the page size taken from the virtual address. Bits [9:0] are the virtual offset.
- R9: Addresses in 0x80000000–0xBFFFFFFF or at or above 0xE0000000 are never looked up. When allowed, they return the low 29 address bits, whatever the table contents or `xlate_en`.
- R10: In user mode, an access to a bypass window outside 0xE0000000–0xE3FFFFFF faults with 0x0E0 for a fetch or a read and with 0x100 for a write.
- R11: With `xlate_en`=0, a non-bypass address returns its low 29 bits without fault.
- R12: On every fault except the multiple hit, `rsp_vpn_valid`=1 and `rsp_vpn` holds address bits [31:10]. Without a fault, `rsp_code` is 0 and `rsp_vpn_valid` is 0.
- R13: Reset clears every valid flag. A table write is seen by requests from the cycle after it is presented; a request in the same cycle sees the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write one table slot |
| wr_idx | input | IDX_W | Slot to write |
| wr_vpn | input | 22 | Virtual page number (address bits 31:10) |
| wr_asid | input | 8 | Address-space tag of the entry |
| wr_valid | input | 1 | Entry valid flag |
| wr_shared | input | 1 | Entry ignores the tag comparison |
| wr_dirty | input | 1 | Page already written |
| wr_prot | input | 2 | Bit 1: user access allowed; bit 0: writable |
| wr_size | input | 2 | Page size code |
| wr_ppn | input | 19 | Physical page number (physical bits 28:10) |
| req_valid | input | 1 | Lookup request strobe |
| req_addr | input | 32 | Virtual address |
| req_kind | input | 2 | 0 fetch, 1 read, 2 write, 3 read |
| priv | input | 1 | Privileged mode |
| single_virt | input | 1 | Single address space mode |
| xlate_en | input | 1 | Translation enable |
| cur_asid | input | 8 | Current address-space tag |
| rsp_valid | output | 1 | Response valid |
| rsp_fault | output | 1 | Access faulted |
| rsp_code | output | 12 | Fault code, 0 when no fault |
| rsp_pa | output | 29 | Physical address |
| rsp_vpn_valid | output | 1 | `rsp_vpn` carries the faulting page number |
| rsp_vpn | output | 22 | Faulting virtual page number |

## Verification
The bench loads pages with the same base bits but different size codes and probes the last and first byte around each boundary. A wrong size mask would turn the hit just inside a 64 KB or 1 MB page into a miss, or leak high virtual bits into the physical page. It probes the tag rules with the shared flag, the privileged single-space case and an invalid slot. A design that got these wrong would report a miss where a hit is due, or translate through a dead slot. It drives overlapping entries, clean writable pages and user accesses to the bypass windows, including the last store-queue byte and the first byte after it. There a wrong priority would report the first-write or miss code instead of a violation, multi-hit or address error, or would expose the page number on a multi-hit. A randomized phase with rewrites of random slots runs alongside the directed cases.

// File: rtl/vtlb_pkg.sv
package vtlb_pkg;
  localparam int VA_W   = 32;
  localparam int OFF_W  = 10;
  localparam int VPN_W  = VA_W - OFF_W;
  localparam int PA_W   = 29;
  localparam int PPN_W  = PA_W - OFF_W;
  localparam int ASID_W = 8;
  localparam int CODE_W = 12;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  localparam logic [CODE_W-1:0] FLT_NONE   = 12'h000;
  localparam logic [CODE_W-1:0] FLT_RMISS  = 12'h040;
  localparam logic [CODE_W-1:0] FLT_WMISS  = 12'h060;
  localparam logic [CODE_W-1:0] FLT_FIRSTW = 12'h080;
  localparam logic [CODE_W-1:0] FLT_RPROT  = 12'h0A0;
  localparam logic [CODE_W-1:0] FLT_WPROT  = 12'h0C0;
  localparam logic [CODE_W-1:0] FLT_RADDR  = 12'h0E0;
  localparam logic [CODE_W-1:0] FLT_WADDR  = 12'h100;
  localparam logic [CODE_W-1:0] FLT_MULTI  = 12'h140;

  typedef struct packed {
    logic              valid;
    logic              shared;
    logic              dirty;
    logic [1:0]        prot;
    logic [1:0]        size;
    logic [VPN_W-1:0]  vpn;
    logic [ASID_W-1:0] asid;
    logic [PPN_W-1:0]  ppn;
  } tlb_ent_t;

  // Page-number bits that take part in the compare for a given size code.
  function automatic logic [VPN_W-1:0] vpn_keep_mask(input logic [1:0] sz);
    logic [VPN_W-1:0] ones;
    ones = '1;
    case (sz)
      2'd0:    return ones;
      2'd1:    return ones << 2;
      2'd2:    return ones << 6;
      default: return ones << 10;
    endcase
  endfunction
endpackage

// File: rtl/vtlb_match.sv
module vtlb_match
  import vtlb_pkg::*;
(
  input  tlb_ent_t          ent,
  input  logic [VPN_W-1:0]  va_vpn,
  input  logic [OFF_W-1:0]  va_off,
  input  logic [ASID_W-1:0] cur_asid,
  input  logic              chk_asid,
  output logic              hit,
  output logic [PA_W-1:0]   pa
);
  logic [VPN_W-1:0] keep;
  logic             tag_ok;
  logic [PPN_W-1:0] page;

  always_comb begin
    keep   = vpn_keep_mask(ent.size);
    tag_ok = ent.shared || !chk_asid || (ent.asid == cur_asid);
    hit    = ent.valid && tag_ok && (((va_vpn ^ ent.vpn) & keep) == '0);
    page   = (ent.ppn & keep[PPN_W-1:0]) | (va_vpn[PPN_W-1:0] & ~keep[PPN_W-1:0]);
    pa     = {page, va_off};
  end
endmodule

// File: rtl/vtlb_classify.sv
module vtlb_classify
  import vtlb_pkg::*;
(
  input  logic [VA_W-1:0]   va,
  input  logic [1:0]        kind,
  input  logic              priv,
  input  logic              xlate_en,
  input  logic              any_hit,
  input  logic              multi_hit,
  input  logic [1:0]        sel_prot,
  input  logic              sel_dirty,
  input  logic [PA_W-1:0]   sel_pa,
  output logic              fault,
  output logic [CODE_W-1:0] code,
  output logic [PA_W-1:0]   pa,
  output logic              vpn_rep
);
  logic is_wr, win_p12, win_p4, win_sq;

  always_comb begin
    is_wr   = (acc_e'(kind) == ACC_WRITE);
    win_p12 = (va[VA_W-1 -: 2] == 2'b10);
    win_p4  = (va[VA_W-1 -: 3] == 3'b111);
    win_sq  = (va[VA_W-1 -: 6] == 6'b111000);
    fault   = 1'b0;
    code    = FLT_NONE;
    pa      = va[PA_W-1:0];
    if (win_p12 || win_p4) begin
      if (!priv && !win_sq) begin
        fault = 1'b1;
        code  = is_wr ? FLT_WADDR : FLT_RADDR;
      end
    end else if (xlate_en) begin
      if (!any_hit) begin
        fault = 1'b1;
        code  = is_wr ? FLT_WMISS : FLT_RMISS;
      end else if (multi_hit) begin
        fault = 1'b1;
        code  = FLT_MULTI;
      end else begin
        pa = sel_pa;
        if (!priv && !sel_prot[1]) begin
          fault = 1'b1;
          code  = is_wr ? FLT_WPROT : FLT_RPROT;
        end else if (is_wr && !sel_prot[0]) begin
          fault = 1'b1;
          code  = FLT_WPROT;
        end else if (is_wr && !sel_dirty) begin
          fault = 1'b1;
          code  = FLT_FIRSTW;
        end
      end
    end
    vpn_rep = fault && (code != FLT_MULTI);
  end
endmodule

// File: rtl/vtlb_xlate.sv
module vtlb_xlate
  import vtlb_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic              wr_valid,
  input  logic              wr_shared,
  input  logic              wr_dirty,
  input  logic [1:0]        wr_prot,
  input  logic [1:0]        wr_size,
  input  logic [PPN_W-1:0]  wr_ppn,
  input  logic              req_valid,
  input  logic [VA_W-1:0]   req_addr,
  input  logic [1:0]        req_kind,
  input  logic              priv,
  input  logic              single_virt,
  input  logic              xlate_en,
  input  logic [ASID_W-1:0] cur_asid,
  output logic              rsp_valid,
  output logic              rsp_fault,
  output logic [CODE_W-1:0] rsp_code,
  output logic [PA_W-1:0]   rsp_pa,
  output logic              rsp_vpn_valid,
  output logic [VPN_W-1:0]  rsp_vpn
);
  tlb_ent_t                ents [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0]  hit_vec;
  logic [PA_W-1:0]         pa_vec [NUM_ENTRIES];
  logic                    chk_asid;
  logic                    any_hit, multi_hit, sel_dirty;
  logic [1:0]              sel_prot;
  logic [PA_W-1:0]         sel_pa;
  logic                    c_fault, c_vpn_rep;
  logic [CODE_W-1:0]       c_code;
  logic [PA_W-1:0]         c_pa;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_ENTRIES; i++) ents[i].valid <= 1'b0;
    end else if (wr_en) begin
      ents[wr_idx] <= '{valid: wr_valid, shared: wr_shared, dirty: wr_dirty,
                        prot: wr_prot, size: wr_size, vpn: wr_vpn,
                        asid: wr_asid, ppn: wr_ppn};
    end
  end

  assign chk_asid = !(priv && single_virt);

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_ent
    vtlb_match u_match (
      .ent      (ents[g]),
      .va_vpn   (req_addr[VA_W-1:OFF_W]),
      .va_off   (req_addr[OFF_W-1:0]),
      .cur_asid (cur_asid),
      .chk_asid (chk_asid),
      .hit      (hit_vec[g]),
      .pa       (pa_vec[g])
    );
  end

  always_comb begin
    any_hit   = 1'b0;
    multi_hit = 1'b0;
    sel_pa    = '0;
    sel_prot  = '0;
    sel_dirty = 1'b0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (hit_vec[i]) begin
        multi_hit = multi_hit | any_hit;
        any_hit   = 1'b1;
        sel_pa    = sel_pa | pa_vec[i];
        sel_prot  = sel_prot | ents[i].prot;
        sel_dirty = sel_dirty | ents[i].dirty;
      end
    end
  end

  vtlb_classify u_classify (
    .va        (req_addr),
    .kind      (req_kind),
    .priv      (priv),
    .xlate_en  (xlate_en),
    .any_hit   (any_hit),
    .multi_hit (multi_hit),
    .sel_prot  (sel_prot),
    .sel_dirty (sel_dirty),
    .sel_pa    (sel_pa),
    .fault     (c_fault),
    .code      (c_code),
    .pa        (c_pa),
    .vpn_rep   (c_vpn_rep)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid     <= 1'b0;
      rsp_fault     <= 1'b0;
      rsp_code      <= FLT_NONE;
      rsp_pa        <= '0;
      rsp_vpn_valid <= 1'b0;
      rsp_vpn       <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_fault     <= c_fault;
        rsp_code      <= c_code;
        rsp_pa        <= c_pa;
        rsp_vpn_valid <= c_vpn_rep;
        rsp_vpn       <= req_addr[VA_W-1:OFF_W];
      end
    end
  end

  AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid); // R1
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid); // R1
  AST_MULTI_HIDES_VPN: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_code == FLT_MULTI) |-> (rsp_fault && !rsp_vpn_valid)); // R4
  AST_FIRSTW_ONLY_WRITE: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_kind != 2'd2) |=> (rsp_code != FLT_FIRSTW)); // R7
  AST_XLATE_OFF_PASS: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !xlate_en && !req_addr[VA_W-1]) |=>
      (!rsp_fault && rsp_pa == $past(req_addr[PA_W-1:0]))); // R11
  AST_CLEAN_RSP: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_fault) |-> (rsp_code == FLT_NONE && !rsp_vpn_valid)); // R12
endmodule

// File: tb/vtlb_xlate_bench.sv
module vtlb_xlate_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;
  localparam int WATCHDOG = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 0;
  logic [2:0]  wr_idx = 0;
  logic [21:0] wr_vpn = 0;
  logic [7:0]  wr_asid = 0;
  logic        wr_valid = 0, wr_shared = 0, wr_dirty = 0;
  logic [1:0]  wr_prot = 0, wr_size = 0;
  logic [18:0] wr_ppn = 0;
  logic        req_valid = 0;
  logic [31:0] req_addr = 0;
  logic [1:0]  req_kind = 0;
  logic        priv = 0, single_virt = 0, xlate_en = 1;
  logic [7:0]  cur_asid = 0;
  logic        rsp_valid, rsp_fault, rsp_vpn_valid;
  logic [11:0] rsp_code;
  logic [28:0] rsp_pa;
  logic [21:0] rsp_vpn;

  always #(CLK_PERIOD/2) clk = ~clk;

  vtlb_xlate #(.NUM_ENTRIES(N)) u_vtlb_xlate (
    .clk, .rst, .wr_en, .wr_idx, .wr_vpn, .wr_asid, .wr_valid, .wr_shared,
    .wr_dirty, .wr_prot, .wr_size, .wr_ppn, .req_valid, .req_addr, .req_kind,
    .priv, .single_virt, .xlate_en, .cur_asid, .rsp_valid, .rsp_fault,
    .rsp_code, .rsp_pa, .rsp_vpn_valid, .rsp_vpn
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  // Reference table
  bit        m_v[N], m_sh[N], m_d[N];
  bit [1:0]  m_pr[N], m_sz[N];
  bit [21:0] m_vpn[N];
  bit [7:0]  m_as[N];
  bit [18:0] m_ppn[N];

  typedef struct {
    bit v; bit f; bit [11:0] code; bit [28:0] pa; bit vv; bit [21:0] vpn; string tag;
  } exp_t;
  exp_t exp_q[$];
  string cur_tag = "R1";

  function automatic exp_t ref_model(bit [31:0] a, bit [1:0] k, bit pv, bit sv, bit xe, bit [7:0] as);
    exp_t e;
    bit wr = (k == 2);
    int hits = 0;
    int sel = 0;
    e.v = 1; e.f = 0; e.code = 0; e.pa = a[28:0]; e.vv = 0; e.vpn = a[31:10];
    if ((a >= 32'h8000_0000 && a < 32'hC000_0000) || a >= 32'hE000_0000) begin
      if (!pv && !(a >= 32'hE000_0000 && a < 32'hE400_0000)) begin
        e.f = 1; e.code = wr ? 12'h100 : 12'h0E0;
      end
    end else if (xe) begin
      for (int i = 0; i < N; i++) begin
        longint sz, st;
        sz = 64'd1024 << ((m_sz[i] == 0) ? 0 : (m_sz[i] == 1) ? 2 : (m_sz[i] == 2) ? 6 : 10);
        st = longint'({m_vpn[i], 10'b0}) & ~(sz - 1);
        if (m_v[i] && (m_sh[i] || (pv && sv) || m_as[i] == as) &&
            longint'(a) >= st && longint'(a) <= st + sz - 1) begin
          hits++; sel = i;
        end
      end
      if (hits == 0) begin e.f = 1; e.code = wr ? 12'h060 : 12'h040; end
      else if (hits > 1) e = '{1, 1, 12'h140, 0, 0, 0, ""};
      else begin
        longint sz;
        sz = 64'd1024 << ((m_sz[sel] == 0) ? 0 : (m_sz[sel] == 1) ? 2 : (m_sz[sel] == 2) ? 6 : 10);
        e.pa = 29'((longint'({m_ppn[sel], 10'b0}) & ~(sz - 1)) | (longint'(a) & (sz - 1)));
        if (!pv && !m_pr[sel][1]) begin e.f = 1; e.code = wr ? 12'h0C0 : 12'h0A0; end
        else if (wr && !m_pr[sel][0]) begin e.f = 1; e.code = 12'h0C0; end
        else if (wr && !m_d[sel]) begin e.f = 1; e.code = 12'h080; end
      end
    end
    e.vv = e.f && (e.code != 12'h140);
    e.vpn = a[31:10];
    return e;
  endfunction

  task automatic cycle();
    exp_t e, g;
    if (req_valid) e = ref_model(req_addr, req_kind, priv, single_virt, xlate_en, cur_asid);
    else begin e = '{0, 0, 0, 0, 0, 0, ""}; end
    e.tag = cur_tag;
    exp_q.push_back(e);
    if (wr_en) begin
      m_v[wr_idx] = wr_valid; m_sh[wr_idx] = wr_shared; m_d[wr_idx] = wr_dirty;
      m_pr[wr_idx] = wr_prot; m_sz[wr_idx] = wr_size; m_vpn[wr_idx] = wr_vpn;
      m_as[wr_idx] = wr_asid; m_ppn[wr_idx] = wr_ppn;
    end
    @(negedge clk);
    g = exp_q.pop_front();
    checks++;
    if (rsp_valid !== g.v) begin
      errors++;
      $display("FAIL %s: rsp_valid=%0b expected %0b", g.tag, rsp_valid, g.v);
    end else if (g.v && (rsp_fault !== g.f || rsp_code !== g.code ||
                 rsp_vpn_valid !== g.vv || (!g.f && rsp_pa !== g.pa) ||
                 (g.vv && rsp_vpn !== g.vpn))) begin
      errors++;
      $display("FAIL %s: fault=%0b code=%h pa=%h vv=%0b vpn=%h expected fault=%0b code=%h pa=%h vv=%0b vpn=%h",
               g.tag, rsp_fault, rsp_code, rsp_pa, rsp_vpn_valid, rsp_vpn,
               g.f, g.code, g.pa, g.vv, g.vpn);
    end
  endtask

  task automatic load(int idx, bit [21:0] vpn, bit [7:0] as, bit v, bit sh, bit d,
                      bit [1:0] pr, bit [1:0] sz, bit [18:0] ppn);
    wr_en = 1; wr_idx = 3'(idx); wr_vpn = vpn; wr_asid = as; wr_valid = v;
    wr_shared = sh; wr_dirty = d; wr_prot = pr; wr_size = sz; wr_ppn = ppn;
    cur_tag = "R13";
    cycle();
    wr_en = 0;
  endtask

  task automatic look(string tag, bit [31:0] a, bit [1:0] k, bit pv, bit sv, bit xe, bit [7:0] as);
    cur_tag = tag;
    req_valid = 1; req_addr = a; req_kind = k; priv = pv; single_virt = sv;
    xlate_en = xe; cur_asid = as;
    cycle();
    req_valid = 0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG && !done) begin
      errors++;
      $display("FAIL R1: watchdog expired at cycle %0d expected end before %0d", cyc, WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin m_v[i] = 0; end
    repeat (3) @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0) begin
      errors++; $display("FAIL R13: rsp_valid=%0b after reset expected 0", rsp_valid);
    end
    rst = 0;
    cur_tag = "R1"; cycle();
    // R13: table empty after reset -> miss
    look("R13", 32'h0004_0ABC, 1, 1, 0, 1, 8'd5);
    load(0, 22'h00100, 8'd5, 1, 0, 1, 2'b11, 2'd1, 19'h12345);
    load(1, 22'h40123, 8'd9, 1, 1, 1, 2'b10, 2'd3, 19'h5ABCD);
    load(2, 22'h80001, 8'd5, 1, 0, 0, 2'b01, 2'd0, 19'h00777);
    load(3, 22'hC0000, 8'd7, 1, 0, 1, 2'b11, 2'd2, 19'h3F0F0);
    load(4, 22'h100000, 8'd5, 1, 1, 1, 2'b11, 2'd1, 19'h00010);
    load(5, 22'h100003, 8'd5, 1, 1, 1, 2'b11, 2'd0, 19'h00020);
    load(6, 22'h140000, 8'd5, 0, 1, 1, 2'b11, 2'd1, 19'h00030);
    load(7, 22'h3FFFFF, 8'd1, 0, 0, 0, 2'b00, 2'd0, 19'h0);
    look("R8", 32'h0004_0ABC, 1, 0, 0, 1, 8'd5);
    look("R8", 32'h0004_0FFF, 2, 0, 0, 1, 8'd5);
    look("R3", 32'h0004_0ABC, 1, 0, 0, 1, 8'd6);
    look("R3", 32'h0004_0ABC, 1, 1, 1, 1, 8'd6);
    look("R3", 32'h0004_0ABC, 1, 1, 0, 1, 8'd6);
    look("R3", 32'h1004_5678, 1, 0, 0, 1, 8'd99);
    look("R3", 32'h5000_0010, 1, 1, 0, 1, 8'd5);
    look("R5", 32'h6000_0000, 0, 1, 0, 1, 8'd5);
    look("R5", 32'h6000_0000, 2, 1, 0, 1, 8'd5);
    look("R5", 32'h6000_0000, 3, 1, 0, 1, 8'd5);
    look("R7", 32'h1004_5678, 2, 1, 0, 1, 8'd5);
    look("R6", 32'h2000_0410, 1, 0, 0, 1, 8'd5);
    look("R6", 32'h2000_0410, 0, 0, 0, 1, 8'd5);
    look("R6", 32'h2000_0410, 2, 0, 0, 1, 8'd5);
    look("R7", 32'h2000_0410, 2, 1, 0, 1, 8'd5);
    look("R7", 32'h2000_0410, 1, 1, 0, 1, 8'd5);
    look("R7", 32'h2000_0410, 0, 1, 0, 1, 8'd5);
    look("R2", 32'h2000_07FF, 1, 1, 0, 1, 8'd5);
    look("R2", 32'h2000_0800, 1, 1, 0, 1, 8'd5);
    look("R2", 32'h3000_FFFC, 2, 1, 0, 1, 8'd7);
    look("R2", 32'h3001_0000, 2, 1, 0, 1, 8'd7);
    look("R2", 32'h100F_FFFF, 0, 0, 0, 1, 8'd0);
    look("R2", 32'h1010_0000, 0, 0, 0, 1, 8'd0);
    look("R4", 32'h4000_0C10, 1, 1, 0, 1, 8'd5);
    look("R4", 32'h4000_0C10, 2, 0, 0, 1, 8'd5);
    look("R4", 32'h4000_0010, 1, 1, 0, 1, 8'd5);
    look("R9", 32'h8123_4567, 1, 1, 0, 1, 8'd5);
    look("R9", 32'hA000_0004, 2, 1, 0, 0, 8'd5);
    look("R9", 32'hF000_0000, 0, 1, 0, 1, 8'd5);
    look("R9", 32'hE000_1000, 2, 0, 0, 1, 8'd5);
    look("R10", 32'hE3FF_FFFF, 1, 0, 0, 1, 8'd5);
    look("R10", 32'hE400_0000, 1, 0, 0, 1, 8'd5);
    look("R10", 32'hE400_0000, 2, 0, 0, 1, 8'd5);
    look("R10", 32'h9000_0000, 0, 0, 0, 1, 8'd5);
    look("R10", 32'hBFFF_FFFC, 2, 0, 0, 1, 8'd5);
    look("R11", 32'h0004_0ABC, 1, 0, 0, 0, 8'd5);
    look("R11", 32'hD234_5678, 2, 0, 0, 0, 8'd5);
    look("R12", 32'hC000_0400, 2, 0, 0, 1, 8'd3);
    // R13: write and same-cycle request see old contents
    wr_en = 1; wr_idx = 3'd7; wr_vpn = 22'h180000; wr_asid = 8'd5; wr_valid = 1;
    wr_shared = 0; wr_dirty = 1; wr_prot = 2'b11; wr_size = 2'd0; wr_ppn = 19'h4444;
    req_valid = 1; req_addr = 32'h6000_0123; req_kind = 1; priv = 1; xlate_en = 1; cur_asid = 8'd5;
    cur_tag = "R13"; cycle();
    wr_en = 0;
    cycle();
    req_valid = 0;
    cur_tag = "R1"; cycle(); cycle();
    // Randomized phase
    for (int n = 0; n < 800; n++) begin
      bit [31:0] bases[10];
      bases = '{32'h0004_0000, 32'h1000_0000, 32'h2000_0400, 32'h3000_0000, 32'h4000_0000,
                32'h5000_0000, 32'h8000_0000, 32'hE000_0000, 32'hE400_0000, 32'hC000_0000};
      if ($urandom % 8 == 0) begin
        wr_en = 1; wr_idx = 3'($urandom); wr_valid = 1'($urandom % 4 != 0);
        wr_vpn = 22'(bases[$urandom % 6] >> 10) | 22'($urandom % 64);
        wr_asid = 8'($urandom % 4); wr_shared = 1'($urandom); wr_dirty = 1'($urandom);
        wr_prot = 2'($urandom); wr_size = 2'($urandom); wr_ppn = 19'($urandom);
      end
      req_valid = 1'($urandom % 4 != 0);
      req_addr = bases[$urandom % 10] + ($urandom % 32'h0012_0000);
      req_kind = 2'($urandom); priv = 1'($urandom); single_virt = 1'($urandom);
      xlate_en = 1'($urandom % 8 != 0); cur_asid = 8'($urandom % 4);
      cur_tag = "R2";
      cycle();
      wr_en = 0;
    end
    req_valid = 0;
    cur_tag = "R1"; cycle();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule